// File: doc/BRIEF.md
# Pipeline Hazard Control Unit

This unit decides, every cycle, how a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) must move to stay correct. It looks at the register fields, write enables and load flags held in the pipeline registers. From these it picks the operand source for each execute-stage operand, and raises hold, bubble and flush controls for the front of the pipeline. The datapath, ALU, memory and branch predictor sit outside it and only exchange signals with it.

Three hazards are covered:

- **Data hazards.** Results still in flight are bypassed to the execute stage. A load followed directly by a reader of its destination costs one bubble.
- **Structural hazard.** The single shared instruction/data memory port goes to the memory stage whenever it needs it, and fetch waits.
- **Control hazard.** A mispredicted branch, resolved in execute, turns the two younger instructions into no-ops.

Read-after-write is the only dependence handled. Write-after-read and write-after-write cannot occur out of order in this pipeline.

The decision logic is combinational, so the controls apply in the same cycle the pipeline-register contents are presented. The clock is used for the temporal checks. An active-low reset forces the younger stages to be flushed while it is held.

Top module: `hazard_ctrl`

## Requirements
- R1: An execute operand whose register index equals the memory-stage destination, with that stage's write enable set and the index nonzero, selects the memory-stage result: select code 2'b10. No stall is raised. With write enable clear, no forward occurs.
- R2: An execute operand that matches only the writeback-stage destination (write enable set, index nonzero) selects code 2'b01. An operand matching neither stage selects the register file, code 2'b00.
- R3: When both the memory and the writeback stage match an operand, the memory stage (the newer producer) is selected: code 2'b10.
- R4: Register index 0 never causes a forward or a load-use stall.
- R5: A load in execute whose nonzero destination is read by a used source of the decode-stage instruction asserts pc_hold_o, ifid_hold_o and idex_bubble_o for that cycle. A load that has already reached the memory stage causes no stall.
- R6: A non-load producer in execute whose destination matches a decode source causes no stall.
- R7: When the memory stage accesses memory, the port goes to it: dmem_grant_o=1 and imem_grant_o=0. In that cycle pc_hold_o=1 and ifid_bubble_o=1, while ifid_hold_o=0 and idex_bubble_o=0. Without such an access, imem_grant_o=1 and dmem_grant_o=0.
- R8: A load-use hazard coinciding with a port conflict asserts pc_hold_o, ifid_hold_o and idex_bubble_o, with ifid_bubble_o=0, and still grants the port to the memory stage.
- R9: A mispredict asserts ifid_flush_o and idex_flush_o. It clears pc_hold_o, ifid_hold_o, ifid_bubble_o and idex_bubble_o, even when a load-use or port stall is present. The port grant still follows the memory-stage access.
- R10: While rst_ni is low, ifid_flush_o and idex_flush_o are 1 and pc_hold_o is 0. After reset, with no hazard present, both flushes are 0.
- R11: A decode source whose used flag is 0 never causes a load-use stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| id_rs_i | input | NUM_SRC*REG_AW | Source register indices of the decode-stage instruction |
| id_rs_used_i | input | NUM_SRC | Per-source flag that the decode instruction reads it |
| ex_rs_i | input | NUM_SRC*REG_AW | Source register indices of the execute-stage instruction |
| ex_rd_i | input | REG_AW | Destination index held in the execute stage |
| ex_wen_i | input | 1 | Execute-stage instruction writes a register |
| ex_load_i | input | 1 | Execute-stage instruction is a load |
| mem_rd_i | input | REG_AW | Destination index held in the memory stage |
| mem_wen_i | input | 1 | Memory-stage instruction writes a register |
| mem_acc_i | input | 1 | Memory-stage instruction uses the memory port |
| wb_rd_i | input | REG_AW | Destination index held in the writeback stage |
| wb_wen_i | input | 1 | Writeback-stage instruction writes a register |
| mispredict_i | input | 1 | Branch in execute was mispredicted |
| fwd_sel_o | output | 2*NUM_SRC | Per-operand bypass select (00 file, 01 writeback, 10 memory) |
| pc_hold_o | output | 1 | Keep the program counter |
| ifid_hold_o | output | 1 | Keep the fetch/decode register |
| ifid_bubble_o | output | 1 | Load a no-op into the fetch/decode register |
| idex_bubble_o | output | 1 | Load a no-op into the decode/execute register |
| ifid_flush_o | output | 1 | Squash the fetch/decode register |
| idex_flush_o | output | 1 | Squash the decode/execute register |
| imem_grant_o | output | 1 | Memory port granted to fetch |
| dmem_grant_o | output | 1 | Memory port granted to the memory stage |

## Verification
Forwarding is tried with these patterns:

- a match in the memory stage only;
- a match in writeback only;
- a match in both stages;
- matches on register 0;
- matches with the write enable clear.

Together they separate the priority order from the gating terms.

Load-use is tried in four ways: a load directly ahead of its reader, a load with an independent instruction between them, an ALU producer in the same slot, and a matching but unused source. These show that only the load's one-stage lag stalls.

Port conflicts, mispredicts and their overlaps with a load-use stall show which control wins when several hazards meet.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_MEM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/hz_fwd_sel.sv
module hz_fwd_sel
  import hz_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] src_i,
  input  logic [REG_AW-1:0] mem_rd_i,
  input  logic              mem_wen_i,
  input  logic [REG_AW-1:0] wb_rd_i,
  input  logic              wb_wen_i,
  output fwd_sel_e          sel_o
);
  logic src_nz, mem_hit, wb_hit;

  assign src_nz  = (src_i != '0);
  assign mem_hit = src_nz && mem_wen_i && (mem_rd_i == src_i);
  assign wb_hit  = src_nz && wb_wen_i && (wb_rd_i == src_i);

  // newer producer first
  always_comb begin
    if (mem_hit)     sel_o = FWD_MEM;
    else if (wb_hit) sel_o = FWD_WB;
    else             sel_o = FWD_RF;
  end

  AST_FWD_ZERO_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i == '0) |-> (sel_o == FWD_RF)); // R4
  AST_FWD_WB_WRITER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o == FWD_WB) |-> (wb_wen_i && wb_rd_i == src_i && !(mem_wen_i && mem_rd_i == src_i))); // R3
  AST_FWD_MEM_WRITER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o == FWD_MEM) |-> (mem_wen_i && mem_rd_i == src_i)); // R1
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use #(
  parameter int NUM_SRC = 2,
  parameter int REG_AW  = 5
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_SRC*REG_AW-1:0] id_rs_i,
  input  logic [NUM_SRC-1:0]        id_rs_used_i,
  input  logic [REG_AW-1:0]         ex_rd_i,
  input  logic                      ex_wen_i,
  input  logic                      ex_load_i,
  output logic                      hit_o
);
  logic [NUM_SRC-1:0] src_hit;
  logic               producer_ok;

  assign producer_ok = ex_load_i && ex_wen_i && (ex_rd_i != '0);

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    assign src_hit[k] = id_rs_used_i[k] && (id_rs_i[k*REG_AW +: REG_AW] == ex_rd_i);
  end

  assign hit_o = producer_ok && (|src_hit);

  AST_LU_NEEDS_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (ex_load_i && ex_rd_i != '0)); // R4
  AST_LU_NEEDS_USED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_rs_used_i == '0) |-> !hit_o); // R11
endmodule

// File: rtl/hz_port_arb.sv
module hz_port_arb (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mem_acc_i,
  output logic imem_grant_o,
  output logic dmem_grant_o,
  output logic conflict_o
);
  // fetch requests every cycle; data access always wins
  assign dmem_grant_o = mem_acc_i;
  assign imem_grant_o = !mem_acc_i;
  assign conflict_o   = mem_acc_i;

  AST_PORT_ONE_OWNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({imem_grant_o, dmem_grant_o})); // R7
  AST_PORT_NEVER_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (imem_grant_o || dmem_grant_o)); // R7
endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
  import hz_pkg::*;
#(
  parameter int NUM_SRC = 2,
  parameter int REG_AW  = 5
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_SRC*REG_AW-1:0] id_rs_i,
  input  logic [NUM_SRC-1:0]        id_rs_used_i,
  input  logic [NUM_SRC*REG_AW-1:0] ex_rs_i,
  input  logic [REG_AW-1:0]         ex_rd_i,
  input  logic                      ex_wen_i,
  input  logic                      ex_load_i,
  input  logic [REG_AW-1:0]         mem_rd_i,
  input  logic                      mem_wen_i,
  input  logic                      mem_acc_i,
  input  logic [REG_AW-1:0]         wb_rd_i,
  input  logic                      wb_wen_i,
  input  logic                      mispredict_i,
  output logic [2*NUM_SRC-1:0]      fwd_sel_o,
  output logic                      pc_hold_o,
  output logic                      ifid_hold_o,
  output logic                      ifid_bubble_o,
  output logic                      idex_bubble_o,
  output logic                      ifid_flush_o,
  output logic                      idex_flush_o,
  output logic                      imem_grant_o,
  output logic                      dmem_grant_o
);
  localparam int SelW = 2;

  logic lu_hit, port_conf, flush, stall_any;

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_fwd
    fwd_sel_e sel;
    hz_fwd_sel #(.REG_AW(REG_AW)) u_fwd (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .src_i    (ex_rs_i[k*REG_AW +: REG_AW]),
      .mem_rd_i (mem_rd_i),
      .mem_wen_i(mem_wen_i),
      .wb_rd_i  (wb_rd_i),
      .wb_wen_i (wb_wen_i),
      .sel_o    (sel)
    );
    assign fwd_sel_o[k*SelW +: SelW] = sel;
  end

  hz_load_use #(.NUM_SRC(NUM_SRC), .REG_AW(REG_AW)) u_lu (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .id_rs_i     (id_rs_i),
    .id_rs_used_i(id_rs_used_i),
    .ex_rd_i     (ex_rd_i),
    .ex_wen_i    (ex_wen_i),
    .ex_load_i   (ex_load_i),
    .hit_o       (lu_hit)
  );

  hz_port_arb u_arb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mem_acc_i   (mem_acc_i),
    .imem_grant_o(imem_grant_o),
    .dmem_grant_o(dmem_grant_o),
    .conflict_o  (port_conf)
  );

  // flush outranks every stall; reset keeps the young stages squashed
  assign flush     = mispredict_i || !rst_ni;
  assign stall_any = (lu_hit || port_conf) && !flush;

  assign ifid_flush_o  = flush;
  assign idex_flush_o  = flush;
  assign pc_hold_o     = stall_any;
  assign ifid_hold_o   = lu_hit && !flush;
  // lost fetch leaves IF/ID empty unless decode must be kept for load-use
  assign ifid_bubble_o = port_conf && !lu_hit && !flush;
  assign idex_bubble_o = lu_hit && !flush;

  AST_FLUSH_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mispredict_i |-> !(pc_hold_o || ifid_hold_o || ifid_bubble_o || idex_bubble_o)); // R9
  AST_BUBBLE_HOLDS_FRONT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idex_bubble_o |-> (pc_hold_o && ifid_hold_o)); // R5
  AST_HOLD_OR_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ifid_hold_o && ifid_bubble_o)); // R8
  AST_PORT_STALLS_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dmem_grant_o && !mispredict_i) |-> pc_hold_o); // R7
endmodule

// File: tb/hazard_ctrl_tb_top.sv
module hazard_ctrl_tb_top;
  localparam int NUM_SRC = 2;
  localparam int REG_AW  = 5;

  typedef struct packed {
    logic [4:0] ir0, ir1;
    logic [1:0] iu;
    logic [4:0] er0, er1, erd;
    logic       ewen, eld;
    logic [4:0] mrd;
    logic       mwen, macc;
    logic [4:0] wrd;
    logic       wwen, misp;
    logic [1:0] f0, f1;
    logic [7:0] ctrl; // {pc_hold, ifid_hold, ifid_bubble, idex_bubble, ifid_flush, idex_flush, imem_grant, dmem_grant}
    logic [3:0] req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{5'd1, 5'd2, 2'b11, 5'd3, 5'd4, 5'd5, 1'b1, 1'b0, 5'd6, 1'b1, 1'b0, 5'd7, 1'b1, 1'b0, 2'b00, 2'b00, 8'h02, 4'd2},  // R2 no match
    '{5'd1, 5'd2, 2'b11, 5'd6, 5'd4, 5'd5, 1'b1, 1'b0, 5'd6, 1'b1, 1'b0, 5'd7, 1'b1, 1'b0, 2'b10, 2'b00, 8'h02, 4'd1},  // R1 mem hit
    '{5'd1, 5'd2, 2'b11, 5'd3, 5'd7, 5'd5, 1'b1, 1'b0, 5'd6, 1'b1, 1'b0, 5'd7, 1'b1, 1'b0, 2'b00, 2'b01, 8'h02, 4'd2},  // R2 wb hit
    '{5'd1, 5'd2, 2'b11, 5'd9, 5'd9, 5'd5, 1'b1, 1'b0, 5'd9, 1'b1, 1'b0, 5'd9, 1'b1, 1'b0, 2'b10, 2'b10, 8'h02, 4'd3},  // R3 both
    '{5'd1, 5'd2, 2'b11, 5'd0, 5'd0, 5'd5, 1'b1, 1'b0, 5'd0, 1'b1, 1'b0, 5'd0, 1'b1, 1'b0, 2'b00, 2'b00, 8'h02, 4'd4},  // R4 fwd x0
    '{5'd0, 5'd2, 2'b11, 5'd3, 5'd4, 5'd0, 1'b1, 1'b1, 5'd6, 1'b1, 1'b0, 5'd7, 1'b1, 1'b0, 2'b00, 2'b00, 8'h02, 4'd4},  // R4 load x0
    '{5'd1, 5'd5, 2'b11, 5'd3, 5'd4, 5'd5, 1'b1, 1'b1, 5'd6, 1'b1, 1'b0, 5'd7, 1'b1, 1'b0, 2'b00, 2'b00, 8'hD2, 4'd5},  // R5 load-use
    '{5'd1, 5'd5, 2'b01, 5'd3, 5'd4, 5'd5, 1'b1, 1'b1, 5'd6, 1'b1, 1'b0, 5'd7, 1'b1, 1'b0, 2'b00, 2'b00, 8'h02, 4'd11}, // R11 unused src
    '{5'd1, 5'd5, 2'b11, 5'd3, 5'd4, 5'd5, 1'b1, 1'b0, 5'd6, 1'b1, 1'b0, 5'd7, 1'b1, 1'b0, 2'b00, 2'b00, 8'h02, 4'd6},  // R6 alu producer
    '{5'd5, 5'd2, 2'b11, 5'd3, 5'd4, 5'd8, 1'b1, 1'b0, 5'd5, 1'b1, 1'b0, 5'd7, 1'b1, 1'b0, 2'b00, 2'b00, 8'h02, 4'd5},  // R5 load in MEM
    '{5'd1, 5'd2, 2'b11, 5'd3, 5'd4, 5'd5, 1'b1, 1'b0, 5'd6, 1'b1, 1'b1, 5'd7, 1'b1, 1'b0, 2'b00, 2'b00, 8'hA1, 4'd7},  // R7 port
    '{5'd1, 5'd5, 2'b11, 5'd3, 5'd4, 5'd5, 1'b1, 1'b1, 5'd6, 1'b1, 1'b1, 5'd7, 1'b1, 1'b0, 2'b00, 2'b00, 8'hD1, 4'd8},  // R8 both stalls
    '{5'd1, 5'd5, 2'b11, 5'd3, 5'd4, 5'd5, 1'b1, 1'b1, 5'd6, 1'b1, 1'b1, 5'd7, 1'b1, 1'b1, 2'b00, 2'b00, 8'h0D, 4'd9},  // R9 flush wins
    '{5'd1, 5'd2, 2'b11, 5'd3, 5'd4, 5'd5, 1'b1, 1'b0, 5'd6, 1'b1, 1'b0, 5'd7, 1'b1, 1'b1, 2'b00, 2'b00, 8'h0E, 4'd9},  // R9 plain
    '{5'd1, 5'd2, 2'b11, 5'd6, 5'd7, 5'd5, 1'b1, 1'b0, 5'd6, 1'b0, 1'b0, 5'd7, 1'b0, 1'b0, 2'b00, 2'b00, 8'h02, 4'd1}   // R1 wen gate
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [NUM_SRC*REG_AW-1:0] id_rs, ex_rs;
  logic [NUM_SRC-1:0] id_rs_used;
  logic [REG_AW-1:0] ex_rd, mem_rd, wb_rd;
  logic ex_wen, ex_load, mem_wen, mem_acc, wb_wen, mispredict;
  logic [2*NUM_SRC-1:0] fwd_sel;
  logic pc_hold, ifid_hold, ifid_bubble, idex_bubble, ifid_flush, idex_flush, imem_grant, dmem_grant;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hazard_ctrl #(.NUM_SRC(NUM_SRC), .REG_AW(REG_AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .id_rs_i(id_rs), .id_rs_used_i(id_rs_used), .ex_rs_i(ex_rs),
    .ex_rd_i(ex_rd), .ex_wen_i(ex_wen), .ex_load_i(ex_load),
    .mem_rd_i(mem_rd), .mem_wen_i(mem_wen), .mem_acc_i(mem_acc),
    .wb_rd_i(wb_rd), .wb_wen_i(wb_wen), .mispredict_i(mispredict),
    .fwd_sel_o(fwd_sel), .pc_hold_o(pc_hold), .ifid_hold_o(ifid_hold),
    .ifid_bubble_o(ifid_bubble), .idex_bubble_o(idex_bubble),
    .ifid_flush_o(ifid_flush), .idex_flush_o(idex_flush),
    .imem_grant_o(imem_grant), .dmem_grant_o(dmem_grant)
  );

  function automatic logic [7:0] ctrl_now();
    return {pc_hold, ifid_hold, ifid_bubble, idex_bubble, ifid_flush, idex_flush, imem_grant, dmem_grant};
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    id_rs = {v.ir1, v.ir0}; id_rs_used = v.iu; ex_rs = {v.er1, v.er0};
    ex_rd = v.erd; ex_wen = v.ewen; ex_load = v.eld;
    mem_rd = v.mrd; mem_wen = v.mwen; mem_acc = v.macc;
    wb_rd = v.wrd; wb_wen = v.wwen; mispredict = v.misp;
  endtask

  initial begin
    drive(VECS[0]);
    #3;
    // R10 reset state
    check("R10 reset ctrl", ctrl_now(), 8'h0E);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk); #1;
    check("R10 after reset ctrl", ctrl_now(), 8'h02);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i]);
      #1;
      check($sformatf("R%0d vec%0d fwd", VECS[i].req, i), {4'b0, fwd_sel}, {4'b0, VECS[i].f1, VECS[i].f0});
      check($sformatf("R%0d vec%0d ctrl", VECS[i].req, i), ctrl_now(), VECS[i].ctrl);
    end

    // R4 load to x0 read by x0 sources on both operands
    @(negedge clk);
    drive(VECS[0]);
    id_rs = '0; ex_rd = '0; ex_load = 1'b1; #1;
    check("R4 x0 load-use", ctrl_now(), 8'h02);

    // R10 reset reasserted mid-run: flush regardless of load-use
    @(negedge clk);
    drive(VECS[6]);
    rst_ni = 1'b0; #1;
    check("R10 reset beats stall", ctrl_now(), 8'h0E);
    @(negedge clk);
    rst_ni = 1'b1; #1;
    check("R5 stall back after reset", ctrl_now(), 8'hD2);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule